// File: doc/BRIEF.md
# Non-Scan State Machine Observability Wrapper

This block wraps a small synchronous state machine with a single test-mode control input, `test_en`. It makes every state of the machine both reachable and directly observable, and it does so without a scan chain. The machine has `NIN` primary inputs, `NOUT` primary outputs and `NST` state flip-flops.

State bit 0 is the reach marker. Every state code that cannot be reached from reset has this bit set. While `test_en` is high, one OR term forces the marker to 1 on the next-state path. As a result, each marker-1 code can be entered from the matching marker-0 code.

In the same mode, the state bits are split into `ceil(NST/NIN)` groups of at most `NIN` bits. Each group drives one output through a multiplexer. The value it drives is the OR, over the group, of each state bit ANDed with the input at the same position. A group that holds a single state bit drives that bit alone. Any two states can therefore be told apart by one input vector. With `test_en` low, the wrapper behaves exactly like the bare machine. If `NST` exceeds `NIN*NOUT`, elaboration stops with an error.

The machine included here is an example core. Its state bits `NST-1:1` form a counter value `v`, and bit 0 is the marker.

Top module: `ns_testwrap`

## Requirements
- R1: A synchronous active-high `rst` loads state code 0, so `v`=0 and the marker is 0.
- R2: With `test_en`=0, each clock sets `v` to `v + pin` modulo 2^(NST-1). The marker becomes 1 only when `v` is all ones and `pin` is all ones. For example, with the default parameters, `v`=15 and `pin`=3 lead to `v`=2 with the marker set.
- R3: With `test_en`=0, the outputs are the core's own. `pout[0]` is the XOR of all bits of `v`, XORed with `pin[0]`. `pout[1]` is the top bit of `v`. `pout[2]` is the AND of all bits of `v`. `pout[3]` is `v[0]` XOR `pin[1]`.
- R4: With `test_en`=1, the next marker is 1 whatever the state and input. The bits of `v` still follow R2, so every marker-1 code is entered from its marker-0 twin.
- R5: With `test_en`=1, output `j` for `j < ceil(NST/NIN)` equals the OR over `i` of `pin[i] & st[j*NIN+i]`, where `st` = {`v`, marker}.
- R6: A group that holds exactly one state bit drives its output with that bit alone. With the default parameters, `pout[2]` equals `v[3]` in test mode.
- R7: In test mode, outputs at or above `ceil(NST/NIN)` pass the core value through unchanged. With the default parameters this is `pout[3]`.
- R8: In test mode, any two distinct state codes give different `pout` values for at least one input vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to state code 0 |
| test_en | input | 1 | Test mode: forces the marker bit and selects the observation outputs |
| pin | input | NIN | Primary inputs |
| pout | output | NOUT | Primary outputs |

## Verification
The assertions assume that `test_en` and `pin` are stable around the rising edge, and that `rst` is high at the first edge. The bench drives every input shortly after an edge and holds `rst` for several cycles at the start. The single-group and pass-through checks also assume the default grouping, where the last group holds one bit and one output lies outside all groups. The stimulus keeps these defaults. It reaches every state code only through the normal input path: it counts with `test_en` low, then raises `test_en` for one cycle to enter each marker-1 twin.

// File: rtl/ns_testwrap_pkg.sv
`timescale 1ns/100ps
package ns_testwrap_pkg;

    // number of observation groups for k state bits and l inputs
    function automatic int unsigned grp_count(input int unsigned k, input int unsigned l);
        return (k + l - 1) / l;
    endfunction

    // width of group j (the last one may be short)
    function automatic int unsigned grp_width(input int unsigned k, input int unsigned l,
                                              input int unsigned j);
        int unsigned rem;
        rem = k - j * l;
        return (rem < l) ? rem : l;
    endfunction

endpackage

// File: rtl/ns_demo_core.sv
`timescale 1ns/100ps
// Example machine: counter value in st[K-1:1], reach marker in st[0].
module ns_demo_core #(
    parameter int unsigned NIN  = 2,
    parameter int unsigned NOUT = 4,
    parameter int unsigned NST  = 5
) (
    input  logic [NST-1:0]  st,
    input  logic [NIN-1:0]  pin,
    output logic [NST-1:0]  nxt,
    output logic [NOUT-1:0] z
);
    localparam int unsigned VW = NST - 1;

    logic [VW-1:0] v;
    logic [VW-1:0] step;

    assign v    = st[NST-1:1];
    assign step = VW'(pin);

    always_comb begin
        nxt[NST-1:1] = v + step;
        nxt[0]       = (&v) & (&pin);
    end

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        if (i == 0) begin : g_par
            assign z[i] = (^v) ^ pin[0];
        end else if (i == 1) begin : g_top
            assign z[i] = v[VW-1];
        end else if (i == 2) begin : g_full
            assign z[i] = &v;
        end else begin : g_mix
            assign z[i] = v[(i-3) % VW] ^ pin[i % NIN];
        end
    end

endmodule

// File: rtl/ns_grp_term.sv
`timescale 1ns/100ps
// AND-OR observation term for one group of at least two state bits.
module ns_grp_term #(
    parameter int unsigned GW = 2
) (
    input  logic [GW-1:0] xin,
    input  logic [GW-1:0] ybits,
    output logic          f
);
    assign f = |(xin & ybits);
endmodule

// File: rtl/ns_obs_mux.sv
`timescale 1ns/100ps
module ns_obs_mux
    import ns_testwrap_pkg::*;
#(
    parameter int unsigned NIN  = 2,
    parameter int unsigned NOUT = 4,
    parameter int unsigned NST  = 5
) (
    input  logic            test_en,
    input  logic [NIN-1:0]  pin,
    input  logic [NST-1:0]  st,
    input  logic [NOUT-1:0] core_z,
    output logic [NOUT-1:0] pout
);
    localparam int unsigned NGRP = grp_count(NST, NIN);

    for (genvar j = 0; j < NOUT; j++) begin : g_o
        if (j < NGRP) begin : g_obs
            localparam int unsigned GW = grp_width(NST, NIN, j);
            logic f;
            if (GW == 1) begin : g_one
                assign f = st[j*NIN];
            end else begin : g_many
                ns_grp_term #(.GW(GW)) i_term (
                    .xin   (pin[GW-1:0]),
                    .ybits (st[j*NIN +: GW]),
                    .f     (f)
                );
            end
            assign pout[j] = test_en ? f : core_z[j];
        end else begin : g_pass
            assign pout[j] = core_z[j];
        end
    end

endmodule

// File: rtl/ns_testwrap.sv
`timescale 1ns/100ps
module ns_testwrap
    import ns_testwrap_pkg::*;
#(
    parameter int unsigned NIN  = 2,
    parameter int unsigned NOUT = 4,
    parameter int unsigned NST  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            test_en,
    input  logic [NIN-1:0]  pin,
    output logic [NOUT-1:0] pout
);
    localparam int unsigned NGRP     = grp_count(NST, NIN);
    localparam logic [NST-1:0] RST_CODE = '0;

    if (NST > NIN * NOUT) begin : g_too_many_state_bits
        $error("ns_testwrap: state bits exceed inputs times outputs");
    end
    if (NST < 2) begin : g_too_few_state_bits
        $error("ns_testwrap: at least two state bits required");
    end

    typedef struct packed {
        logic [NST-1:0] st;
    } regs_t;

    regs_t r_d, r_q;

    logic [NST-1:0]  core_nxt;
    logic [NOUT-1:0] core_z;
    logic [NST-1:0]  st_q;

    assign st_q = r_q.st;

    ns_demo_core #(.NIN(NIN), .NOUT(NOUT), .NST(NST)) i_core (
        .st  (r_q.st),
        .pin (pin),
        .nxt (core_nxt),
        .z   (core_z)
    );

    always_comb begin
        r_d       = r_q;
        r_d.st    = core_nxt;
        r_d.st[0] = core_nxt[0] | test_en;   // marker forced in test mode
        if (rst) begin
            r_d.st = RST_CODE;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    ns_obs_mux #(.NIN(NIN), .NOUT(NOUT), .NST(NST)) i_obs (
        .test_en (test_en),
        .pin     (pin),
        .st      (r_q.st),
        .core_z  (core_z),
        .pout    (pout)
    );

endmodule

module ns_testwrap_chk
    import ns_testwrap_pkg::*;
#(
    parameter int unsigned NIN  = 2,
    parameter int unsigned NOUT = 4,
    parameter int unsigned NST  = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            test_en,
    input logic [NIN-1:0]  pin,
    input logic [NOUT-1:0] pout,
    input logic [NST-1:0]  st_q,
    input logic [NST-1:0]  core_nxt,
    input logic [NOUT-1:0] core_z
);
    localparam int unsigned NGRP = grp_count(NST, NIN);
    localparam int unsigned LASTW = grp_width(NST, NIN, NGRP - 1);

    a_r1_reset_code: assert property (@(posedge clk)
        rst |=> (st_q == '0));

    a_r2_follows_core: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> (st_q == $past(core_nxt)));

    a_r3_normal_outputs: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> (pout == core_z));

    a_r4_marker_forced: assert property (@(posedge clk) disable iff (rst)
        test_en |=> st_q[0]);

    if (grp_width(NST, NIN, 0) > 1) begin : g_r5
        a_r5_zero_vector: assert property (@(posedge clk) disable iff (rst)
            (test_en && pin == '0) |-> !pout[0]);
    end

    if (LASTW == 1) begin : g_r6
        a_r6_single_bit: assert property (@(posedge clk) disable iff (rst)
            test_en |-> (pout[NGRP-1] == st_q[NST-1]));
    end

    if (NGRP < NOUT) begin : g_r7
        a_r7_passthrough: assert property (@(posedge clk) disable iff (rst)
            test_en |-> (pout[NOUT-1:NGRP] == core_z[NOUT-1:NGRP]));
    end

endmodule

bind ns_testwrap ns_testwrap_chk #(.NIN(NIN), .NOUT(NOUT), .NST(NST)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .test_en  (test_en),
    .pin      (pin),
    .pout     (pout),
    .st_q     (st_q),
    .core_nxt (core_nxt),
    .core_z   (core_z)
);

// File: tb/test_ns_testwrap.sv
`timescale 1ns/100ps
module test_ns_testwrap;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_en = 1'b0;
    logic [1:0] pin = 2'b00;
    logic [3:0] pout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] sig [32];

    always #2 clk = ~clk;   // 250 MHz

    ns_testwrap #(.NIN(2), .NOUT(4), .NST(5)) i_ns_testwrap (
        .clk     (clk),
        .rst     (rst),
        .test_en (test_en),
        .pin     (pin),
        .pout    (pout)
    );

    // normal-mode walk from state 0: {pin, expected pout for the current state}
    localparam logic [5:0] TBL [11] = '{
        {2'd1, 4'b0001},   // v=0
        {2'd3, 4'b0000},   // v=1
        {2'd2, 4'b1001},   // v=4
        {2'd3, 4'b1001},   // v=6
        {2'd0, 4'b1010},   // v=9
        {2'd2, 4'b0010},   // v=9
        {2'd3, 4'b0010},   // v=11
        {2'd1, 4'b0010},   // v=14
        {2'd0, 4'b1110},   // v=15
        {2'd1, 4'b1111},   // v=15, wraps to 0
        {2'd0, 4'b0000}    // v=0
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp_v, $time);
        end
    endtask

    // expected test-mode outputs from the grouping rules (st = {v, marker})
    function automatic logic [3:0] exp_test(input int v, input int b, input logic [1:0] p);
        logic [4:0] st;
        logic [3:0] e;
        st   = {v[3:0], b[0]};
        e[0] = (p[0] & st[0]) | (p[1] & st[1]);
        e[1] = (p[0] & st[2]) | (p[1] & st[3]);
        e[2] = st[4];
        e[3] = st[1] ^ p[1];
        return e;
    endfunction

    task automatic probe(input int v, input int b, input bit rec, input string req);
        logic [3:0] e;
        test_en = 1'b1;
        for (int p = 0; p < 4; p++) begin
            pin = p[1:0];
            #0.3;
            e = exp_test(v, b, p[1:0]);
            chk({req, " R5 groups"}, {2'b00, pout[1:0]}, {2'b00, e[1:0]});
            chk({req, " R6 single bit"}, {3'b000, pout[2]}, {3'b000, e[2]});
            chk({req, " R7 passthrough"}, {3'b000, pout[3]}, {3'b000, e[3]});
            if (rec) sig[v*2 + b][p*4 +: 4] = pout;
        end
    endtask

    task automatic step(input logic te, input logic [1:0] p);
        test_en = te;
        pin = p;
        @(posedge clk);
        #0.2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #0.2;
        rst = 1'b0;

        // R1: reset code 0 seen through test-mode outputs and normal outputs
        probe(0, 0, 1'b0, "R1");
        test_en = 1'b0; pin = 2'd0; #0.3;
        chk("R1 normal outputs at reset", pout, 4'b0000);

        // R2 / R3: table walk in normal mode
        for (int i = 0; i < 11; i++) begin
            test_en = 1'b0;
            pin = TBL[i][5:4];
            #0.5;
            chk("R3/R2 normal mode", pout, TBL[i][3:0]);
            @(posedge clk);
            #0.2;
        end

        // R4 / R5: visit every code, marker-1 twin via one test cycle
        for (int v = 0; v < 16; v++) begin
            probe(v, 0, 1'b1, "R5 twin0");
            step(1'b1, 2'd0);
            probe(v, 1, 1'b1, "R4 twin1");
            if (v < 15) step(1'b0, 2'd1);
        end

        // R8: every pair of codes separated by some single vector
        for (int a = 0; a < 32; a++) begin
            for (int c = a + 1; c < 32; c++) begin
                checks++;
                if (sig[a] === sig[c]) begin
                    errors++;
                    $display("FAIL R8: codes %0d and %0d actual %h expected differing from %h",
                             a, c, sig[a], sig[c]);
                end
            end
        end

        // R2 corner: marker set from v=15 with all-ones input, 15+3 wraps to 2
        step(1'b0, 2'd0);
        probe(15, 0, 1'b0, "R2 marker cleared");
        step(1'b0, 2'd3);
        probe(2, 1, 1'b0, "R2 marker set");

        // R1: reset from a non-zero state
        rst = 1'b1;
        step(1'b0, 2'd1);
        rst = 1'b0;
        probe(0, 0, 1'b0, "R1 re-reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule